// File: doc/BRIEF.md
# Serial Two-Operand Adder Sequencer

This block sits between a byte-level serial receiver and a byte-level serial transmitter. It collects four received bytes that form two 16-bit unsigned operands, adds them, and sends the 16-bit result back as two bytes. The result also stays on a parallel output for a display, with the carry of the addition on its own output. When the second result byte has gone out, the block starts over and waits for the next pair.

On the receive side, the block takes a byte when the receiver raises its converted flag. It then sends a one-cycle flush pulse so that the receiver clears itself. The receiver's oversampling clock drifts against the byte timing, so converted can stay high for several cycles after the flush. A guard therefore accepts no further byte until converted has fallen. On the transmit side, a byte is launched with a one-cycle start pulse only while the transmitter is idle. The next byte waits until busy has risen and then fallen again.

Top module: `serial_adder_ctrl`

## Requirements
- R1: Bytes are consumed in the fixed order first-operand low, first-operand high, second-operand low, second-operand high. Each operand is {high byte, low byte}.
- R2: While fewer than four bytes of a pair have been consumed, `sum_disp` and `carry` keep the values from the previous pair (or from reset). A low byte is held internally until its high byte arrives.
- R3: Every consumed byte produces exactly one `rx_flush` pulse, and that pulse is one cycle wide.
- R4: A `rx_converted` level that stays high after a flush is not counted again. The next byte is taken only after `rx_converted` has been seen low once the flush is over.
- R5: After the fourth byte, `sum_disp` shows (A + B) mod 65536 and `carry` shows bit 16 of A + B. Both hold until the next pair's addition.
- R6: The result goes out low byte first, then high byte, on `tx_byte` together with a one-cycle `tx_start` pulse. `tx_start` is never raised in a cycle that follows a cycle with `tx_busy` high. The second byte waits until `tx_busy` has risen and fallen for the first.
- R7: After the high result byte has finished transmitting, the block accepts a new pair with no outside action.
- R8: Synchronous reset (`rst` high at a clock edge) clears the result, the carry, the held bytes and the sequence position. A partly received pair is discarded, and `rx_flush` and `tx_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Byte presented by the receiver |
| rx_converted | input | 1 | Receiver indicates a byte is ready |
| rx_flush | output | 1 | One-cycle pulse telling the receiver to clear and go idle |
| tx_byte | output | 8 | Byte handed to the transmitter |
| tx_start | output | 1 | One-cycle pulse asking the transmitter to send `tx_byte` |
| tx_busy | input | 1 | Transmitter is sending |
| sum_disp | output | 16 | Latest 16-bit result, for display |
| carry | output | 1 | Carry out of the latest addition |

## Verification
Operand pairs come from two sources: directed extremes and seeded random values. The extremes are zero plus zero, all-ones plus one (wraps to zero with carry), all-ones plus all-ones and two values with only the top bit set. They separate a correct 16-bit wrap and carry from a truncated or sign-extended adder. Random pairs with distinct high and low bytes show whether operand halves or result bytes are swapped. The model receiver holds converted high for a random number of cycles after each flush, once for a long stretch. The flush count per pair then shows whether the guard lets a byte be counted twice. A reset that arrives after a lone byte, followed by a full pair, shows whether a stale low byte leaks into the next operand.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    // Sequence position of the operand/result controller.
    typedef enum logic [2:0] {
        ST_A_LO    = 3'd0,
        ST_A_HI    = 3'd1,
        ST_B_LO    = 3'd2,
        ST_B_HI    = 3'd3,
        ST_ADD     = 3'd4,
        ST_SEND_LO = 3'd5,
        ST_SEND_HI = 3'd6
    } ctl_state_e;

    // Phases of one transmitter byte launch.
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_DRAIN = 2'd2
    } tx_state_e;

endpackage

// File: rtl/sadd_rx_gate.sv
// Consumes one receiver byte per converted indication, issues the flush
// pulse and blocks re-counting until converted has fallen.
module sadd_rx_gate (
    input  logic clk,
    input  logic rst,
    input  logic rx_converted,
    input  logic accept,
    output logic take,
    output logic rx_flush
);

    typedef struct packed {
        logic allow;
        logic flush;
    } gate_t;

    gate_t gate_d, gate_q;

    assign take     = accept && rx_converted && gate_q.allow;
    assign rx_flush = gate_q.flush;

    always_comb begin
        gate_d       = gate_q;
        gate_d.flush = take;
        if (take) begin
            gate_d.allow = 1'b0;
        end else if (!gate_q.allow && !gate_q.flush && !rx_converted) begin
            gate_d.allow = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q.allow <= 1'b1;
            gate_q.flush <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    // R3
    flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> !rx_flush)
        else $error("flush wider than one cycle");

    // R4
    no_retake_chk: assert property (@(posedge clk) disable iff (rst)
        rx_flush |-> !take)
        else $error("byte taken during its own flush");

endmodule

// File: rtl/sadd_tx_seq.sv
// Launches one byte to the transmitter and reports when it has finished.
module sadd_tx_seq #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [BYTE_W-1:0] req_byte,
    input  logic              tx_busy,
    output logic              tx_start,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              done
);
    import sadd_pkg::*;

    typedef struct packed {
        tx_state_e         st;
        logic              start;
        logic [BYTE_W-1:0] data;
    } seq_t;

    seq_t seq_d, seq_q;

    assign tx_start = seq_q.start;
    assign tx_byte  = seq_q.data;
    assign done     = (seq_q.st == TX_DRAIN) && !tx_busy;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        case (seq_q.st)
            TX_IDLE: begin
                if (req && !tx_busy) begin
                    seq_d.start = 1'b1;
                    seq_d.data  = req_byte;
                    seq_d.st    = TX_ARMED;
                end
            end
            TX_ARMED: begin
                if (tx_busy) seq_d.st = TX_DRAIN;
            end
            TX_DRAIN: begin
                if (!tx_busy) seq_d.st = TX_IDLE;
            end
            default: seq_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.st    <= TX_IDLE;
            seq_q.start <= 1'b0;
            seq_q.data  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> !$past(tx_busy))
        else $error("start issued while transmitter busy");

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start)
        else $error("start wider than one cycle");

endmodule

// File: rtl/serial_adder_ctrl.sv
module serial_adder_ctrl #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [BYTE_W-1:0]   rx_byte,
    input  logic                rx_converted,
    output logic                rx_flush,
    output logic [BYTE_W-1:0]   tx_byte,
    output logic                tx_start,
    input  logic                tx_busy,
    output logic [2*BYTE_W-1:0] sum_disp,
    output logic                carry
);
    import sadd_pkg::*;

    localparam int OPND_W = 2 * BYTE_W;

    typedef struct packed {
        ctl_state_e        st;
        logic [BYTE_W-1:0] lo_buf;
        logic [OPND_W-1:0] opa;
        logic [OPND_W-1:0] opb;
        logic [OPND_W-1:0] sum;
        logic              cy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              accept;
    logic              take;
    logic              tx_req;
    logic [BYTE_W-1:0] tx_req_byte;
    logic              tx_done;
    logic [OPND_W:0]   total;

    assign accept = (ctl_q.st == ST_A_LO) || (ctl_q.st == ST_A_HI) ||
                    (ctl_q.st == ST_B_LO) || (ctl_q.st == ST_B_HI);

    sadd_rx_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .rx_converted (rx_converted),
        .accept       (accept),
        .take         (take),
        .rx_flush     (rx_flush)
    );

    sadd_tx_seq #(.BYTE_W(BYTE_W)) u_txseq (
        .clk      (clk),
        .rst      (rst),
        .req      (tx_req),
        .req_byte (tx_req_byte),
        .tx_busy  (tx_busy),
        .tx_start (tx_start),
        .tx_byte  (tx_byte),
        .done     (tx_done)
    );

    assign total = {1'b0, ctl_q.opa} + {1'b0, ctl_q.opb};

    always_comb begin
        ctl_d       = ctl_q;
        tx_req      = 1'b0;
        tx_req_byte = ctl_q.sum[BYTE_W-1:0];
        case (ctl_q.st)
            ST_A_LO: begin
                if (take) begin
                    ctl_d.lo_buf = rx_byte;
                    ctl_d.st     = ST_A_HI;
                end
            end
            ST_A_HI: begin
                if (take) begin
                    ctl_d.opa = {rx_byte, ctl_q.lo_buf};
                    ctl_d.st  = ST_B_LO;
                end
            end
            ST_B_LO: begin
                if (take) begin
                    ctl_d.lo_buf = rx_byte;
                    ctl_d.st     = ST_B_HI;
                end
            end
            ST_B_HI: begin
                if (take) begin
                    ctl_d.opb = {rx_byte, ctl_q.lo_buf};
                    ctl_d.st  = ST_ADD;
                end
            end
            ST_ADD: begin
                ctl_d.sum = total[OPND_W-1:0];
                ctl_d.cy  = total[OPND_W];
                ctl_d.st  = ST_SEND_LO;
            end
            ST_SEND_LO: begin
                tx_req      = 1'b1;
                tx_req_byte = ctl_q.sum[BYTE_W-1:0];
                if (tx_done) ctl_d.st = ST_SEND_HI;
            end
            ST_SEND_HI: begin
                tx_req      = 1'b1;
                tx_req_byte = ctl_q.sum[OPND_W-1:BYTE_W];
                if (tx_done) ctl_d.st = ST_A_LO;
            end
            default: ctl_d.st = ST_A_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st     <= ST_A_LO;
            ctl_q.lo_buf <= '0;
            ctl_q.opa    <= '0;
            ctl_q.opb    <= '0;
            ctl_q.sum    <= '0;
            ctl_q.cy     <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sum_disp = ctl_q.sum;
    assign carry    = ctl_q.cy;

    // R2
    sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st != ST_ADD) |=> ($stable(sum_disp) && $stable(carry)))
        else $error("result changed outside the add step");

    // R1
    fourth_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (take && ctl_q.st == ST_B_HI) |=> (ctl_q.st == ST_ADD))
        else $error("fourth byte did not lead to the add step");

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_SEND_HI && tx_done) |=> (ctl_q.st == ST_A_LO))
        else $error("no restart after the high result byte");

    // R6
    no_start_in_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && $past(accept)) |-> !tx_start)
        else $error("transmit started while collecting operands");

endmodule

// File: tb/sim_serial_adder_ctrl.sv
module sim_serial_adder_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_converted = 1'b0;
    logic        rx_flush;
    logic [7:0]  tx_byte;
    logic        tx_start;
    logic        tx_busy = 1'b0;
    logic [15:0] sum_disp;
    logic        carry;

    always #4 clk = ~clk;

    serial_adder_ctrl u0 (
        .clk          (clk),
        .rst          (rst),
        .rx_byte      (rx_byte),
        .rx_converted (rx_converted),
        .rx_flush     (rx_flush),
        .tx_byte      (tx_byte),
        .tx_start     (tx_start),
        .tx_busy      (tx_busy),
        .sum_disp     (sum_disp),
        .carry        (carry)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int flush_seen = 0;
    int tx_cnt = 0;
    int start_while_busy = 0;
    int busy_left = 0;
    int cyc = 0;
    logic [7:0] tx_log [0:63];

    // Model transmitter and flush counter, sampled on the falling edge.
    always @(negedge clk) begin
        if (rx_flush) flush_seen++;
        if (tx_start) begin
            if (tx_busy) start_while_busy++;
            tx_log[tx_cnt & 63] = tx_byte;
            tx_cnt++;
            busy_left = 2 + $urandom_range(6);
            tx_busy = 1'b1;
        end else if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) tx_busy = 1'b0;
        end
    end

    function automatic logic [16:0] exp_total(input logic [15:0] a, input logic [15:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic send_byte(input logic [7:0] b, input int hold);
        int w;
        @(negedge clk);
        rx_byte = b;
        rx_converted = 1'b1;
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!rx_flush && w < 200);
        repeat (hold) @(negedge clk);
        rx_converted = 1'b0;
        rx_byte = 8'($urandom);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_pair(input logic [15:0] a, input logic [15:0] b, input int hold_max);
        logic [16:0] e;
        logic [15:0] prev_sum;
        logic        prev_cy;
        int f0, t0, w;
        e = exp_total(a, b);
        f0 = flush_seen;
        t0 = tx_cnt;
        prev_sum = sum_disp;
        prev_cy  = carry;
        send_byte(a[7:0],  $urandom_range(hold_max));
        send_byte(a[15:8], $urandom_range(hold_max));
        send_byte(b[7:0],  hold_max);
        // R2: three bytes in, result still from before
        chk("R2 sum held mid-pair", {16'h0, sum_disp}, {16'h0, prev_sum});
        chk("R2 carry held mid-pair", {31'h0, carry}, {31'h0, prev_cy});
        send_byte(b[15:8], $urandom_range(hold_max));
        w = 0;
        while (((tx_cnt - t0) < 2 || tx_busy) && w < 2000) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
        chk("R1 R5 sum", {16'h0, sum_disp}, {16'h0, e[15:0]});
        chk("R5 carry", {31'h0, carry}, {31'h0, e[16]});
        chk("R6 bytes sent", tx_cnt - t0, 2);
        chk("R6 low byte first", {24'h0, tx_log[t0 & 63]}, {24'h0, e[7:0]});
        chk("R6 high byte second", {24'h0, tx_log[(t0 + 1) & 63]}, {24'h0, e[15:8]});
        chk("R3 R4 one flush per byte", flush_seen - f0, 4);
        chk("R6 no start while busy", start_while_busy, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 sum after reset", {16'h0, sum_disp}, 32'h0);
        chk("R8 carry after reset", {31'h0, carry}, 32'h0);
        chk("R8 flush after reset", {31'h0, rx_flush}, 32'h0);
        chk("R8 start after reset", {31'h0, tx_start}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // Directed corners; the R7 restart is shown by each following pair.
        run_pair(16'h0000, 16'h0000, 2);
        run_pair(16'hFFFF, 16'h0001, 3);
        run_pair(16'hFFFF, 16'hFFFF, 1);
        run_pair(16'h8000, 16'h8000, 0);
        // R4: converted held high a long time after each flush
        run_pair(16'h1234, 16'h4321, 12);
        chk("R7 ready after pair", {31'h0, rx_flush}, 32'h0);

        for (int i = 0; i < 15; i++) begin
            run_pair(16'($urandom), 16'($urandom), 6);
        end

        // R8: reset after a lone byte discards it
        send_byte(8'hAA, 1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 sum cleared by reset", {16'h0, sum_disp}, 32'h0);
        chk("R8 carry cleared by reset", {31'h0, carry}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        run_pair(16'h00C3, 16'h5A00, 2);
        run_pair(16'h7FFF, 16'h0001, 4);

        summary();
        $finish;
    end

endmodule